// File: doc/BRIEF.md
# Transmit Bit Retiming Handshake Unit

This block sits between a host that produces serial transmit data by toggling pins in software and the data input of an FSK modulator. Two host pins drive it. The data pin carries the bit value. The strobe pin both selects the mode and loads bits. An internal divider produces one tick per bit period from the system clock. At each tick the block samples the strobe level. A high strobe makes the path transparent, so the modulator sees the data pin directly. A low strobe selects retimed operation: the modulator sees a registered bit, and an active-low request output asks the host for the next bit.

In retimed mode the host waits until the request goes low. It then sets the data pin and pulses the strobe high and back low. The rising strobe edge captures the data into a holding stage, and the high strobe level withdraws the request. At the next tick the held bit moves to an output stage, and that stage drives the modulator for one full bit period. Both host pins pass through two-flop synchronizers before use.

The mode logic is one state machine with three states. ST_PASS is the transparent mode. ST_RT_REQ is retimed with the request active. ST_RT_HELD is retimed after the host has raised the strobe, with the request withdrawn. There are three transitions:
- At every tick the machine goes to ST_PASS if the synchronized strobe is high, and to ST_RT_REQ if it is low.
- Between ticks, ST_RT_REQ goes to ST_RT_HELD when the synchronized strobe is high.
- Every other case holds the current state.

Top module: `tx_bit_retimer`

## Requirements
- R1: While reset is applied and right after it, mod_data is 1 (mark) and load_req_n is 1. The holding stage and the output stage both reset to 1.
- R2: In ST_PASS, mod_data equals host_data as it stood two clock edges earlier (the synchronizer delay). Holding host_strobe high at all times keeps the block transparent.
- R3: When tick_en is high, the divider produces a tick lasting one cycle every DIV_CYCLES cycles. When tick_en is low, no tick occurs, so the mode and load_req_n keep their values.
- R4: The mode is chosen only at a tick, from the synchronized strobe level: high selects ST_PASS, low selects retimed. The choice holds until the next tick.
- R5: In retimed mode, mod_data is the output stage. It changes only at a tick.
- R6: At a tick with the synchronized strobe low, load_req_n goes to 0 on that edge.
- R7: In ST_RT_REQ, a high synchronized strobe sets load_req_n back to 1 on the next edge. This is three clock edges after host_strobe rises.
- R8: A rising edge of the synchronized strobe loads the synchronized host_data into the holding stage. The next tick moves that bit to mod_data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| host_data | input | 1 | Asynchronous serial data from the host |
| host_strobe | input | 1 | Asynchronous host strobe: its level selects the mode and its rising edge loads a bit |
| tick_en | input | 1 | Enables the bit-period divider |
| mod_data | output | 1 | Data bit to the FSK modulator |
| load_req_n | output | 1 | Active-low request for the next bit |

## Verification
The block is tried with four input patterns. A strobe held high with changing data shows that the path is transparent with a two-cycle delay. A strobe held low with tick_en gated off shows that the mode cannot change without a tick. A host that follows the handshake and sends random bits shows that each bit appears exactly at the tick after its strobe pulse and stays stable until the next tick. Random strobe and data activity, with occasional gaps in tick_en, runs alongside a cycle-level model built from the requirements. It covers strobe edges that fall close to a tick and mode switches in both directions.

// File: rtl/retime_pkg.sv
package retime_pkg;

    typedef enum logic [1:0] {
        ST_PASS    = 2'd0,
        ST_RT_REQ  = 2'd1,
        ST_RT_HELD = 2'd2
    } mode_state_t;

    localparam logic MARK = 1'b1;

endpackage

// File: rtl/retime_sync.sv
module retime_sync #(
    parameter int          WIDTH     = 1,
    parameter int          STAGES    = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] pipe [STAGES];

    always_ff @(posedge clk) begin
        if (rst) pipe[0] <= RESET_VAL;
        else     pipe[0] <= async_i;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) pipe[s] <= RESET_VAL;
            else     pipe[s] <= pipe[s-1];
        end
    end

    assign sync_o = pipe[STAGES-1];

endmodule

// File: rtl/retime_tick.sv
module retime_tick #(
    parameter int DIV_CYCLES = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic en_i,
    output logic tick_o
);

    localparam int CW = (DIV_CYCLES > 1) ? $clog2(DIV_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV_CYCLES - 1);

    logic [CW-1:0] cnt_q;

    assign tick_o = en_i && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst)               cnt_q <= '0;
        else if (en_i) begin
            if (cnt_q == LAST) cnt_q <= '0;
            else               cnt_q <= cnt_q + 1'b1;
        end
    end

    if (DIV_CYCLES > 1) begin : g_tick_chk
        // R3: a tick never lasts two cycles
        p_single_pulse_r3: assert property (@(posedge clk) disable iff (rst)
            tick_o |=> !tick_o);
    end

endmodule

// File: rtl/retime_fsm.sv
module retime_fsm
    import retime_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        tick_i,
    input  logic        strobe_i,
    output logic        retimed_o,
    output logic        ready_n_o
);

    mode_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (tick_i) begin
            state_d = strobe_i ? ST_PASS : ST_RT_REQ;
        end else begin
            unique case (state_q)
                ST_PASS:    state_d = ST_PASS;
                ST_RT_REQ:  state_d = strobe_i ? ST_RT_HELD : ST_RT_REQ;
                ST_RT_HELD: state_d = ST_RT_HELD;
                default:    state_d = ST_PASS;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_PASS;
        else     state_q <= state_d;
    end

    always_comb begin
        retimed_o = 1'b0;
        ready_n_o = 1'b1;
        unique case (state_q)
            ST_PASS:    begin retimed_o = 1'b0; ready_n_o = 1'b1; end
            ST_RT_REQ:  begin retimed_o = 1'b1; ready_n_o = 1'b0; end
            ST_RT_HELD: begin retimed_o = 1'b1; ready_n_o = 1'b1; end
            default:    begin retimed_o = 1'b0; ready_n_o = 1'b1; end
        endcase
    end

    // R4: mode changes only at a tick
    p_mode_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !tick_i |=> $stable(retimed_o));

    // R6: low strobe at a tick raises the request
    p_req_on_tick_r6: assert property (@(posedge clk) disable iff (rst)
        (tick_i && !strobe_i) |=> !ready_n_o);

    // R7: strobe high between ticks withdraws the request
    p_release_r7: assert property (@(posedge clk) disable iff (rst)
        (!ready_n_o && strobe_i && !tick_i) |=> ready_n_o);

endmodule

// File: rtl/tx_bit_retimer.sv
module tx_bit_retimer
    import retime_pkg::*;
#(
    parameter int DIV_CYCLES  = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic host_data,
    input  logic host_strobe,
    input  logic tick_en,
    output logic mod_data,
    output logic load_req_n
);

    logic [1:0] pins_s;
    logic       data_s, strobe_s, strobe_d;
    logic       strobe_rise;
    logic       tick;
    logic       hold_q, out_q;
    logic       retimed;

    retime_sync #(
        .WIDTH     (2),
        .STAGES    (SYNC_STAGES),
        .RESET_VAL ({MARK, 1'b1})
    ) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i ({host_data, host_strobe}),
        .sync_o  (pins_s)
    );

    assign data_s   = pins_s[1];
    assign strobe_s = pins_s[0];

    always_ff @(posedge clk) begin
        if (rst) strobe_d <= 1'b1;
        else     strobe_d <= strobe_s;
    end

    assign strobe_rise = strobe_s && !strobe_d;

    retime_tick #(
        .DIV_CYCLES (DIV_CYCLES)
    ) u_tick (
        .clk    (clk),
        .rst    (rst),
        .en_i   (tick_en),
        .tick_o (tick)
    );

    // holding stage: loaded by the host strobe edge
    always_ff @(posedge clk) begin
        if (rst)              hold_q <= MARK;
        else if (strobe_rise) hold_q <= data_s;
    end

    // output stage: loaded on the bit tick
    always_ff @(posedge clk) begin
        if (rst)       out_q <= MARK;
        else if (tick) out_q <= hold_q;
    end

    retime_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .tick_i    (tick),
        .strobe_i  (strobe_s),
        .retimed_o (retimed),
        .ready_n_o (load_req_n)
    );

    assign mod_data = retimed ? out_q : data_s;

    // R5: retimed output is frozen between ticks
    p_retimed_stable_r5: assert property (@(posedge clk) disable iff (rst)
        (retimed && !tick) |=> $stable(mod_data));

    // R2: high strobe at a tick selects the transparent path
    p_pass_follow_r2: assert property (@(posedge clk) disable iff (rst)
        (tick && strobe_s) |=> (mod_data == data_s));

    // R8: strobe edge captures the data bit
    p_capture_r8: assert property (@(posedge clk) disable iff (rst)
        strobe_rise |=> (hold_q == $past(data_s)));

endmodule

// File: tb/tx_bit_retimer_test.sv
module tx_bit_retimer_test;

    localparam int CLK_PERIOD = 10;
    localparam int DIV        = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic host_data = 1'b1;
    logic host_strobe = 1'b1;
    logic tick_en = 1'b1;
    logic mod_data, load_req_n;

    int checks = 0;
    int errors = 0;
    bit cmp_on = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tx_bit_retimer #(.DIV_CYCLES(DIV)) uut (
        .clk         (clk),
        .rst         (rst),
        .host_data   (host_data),
        .host_strobe (host_strobe),
        .tick_en     (tick_en),
        .mod_data    (mod_data),
        .load_req_n  (load_req_n)
    );

    task automatic check(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    // cycle model built from the requirements
    logic m_d1, m_d, m_s1, m_s, m_sd, m_hold, m_out, m_rt, m_req_n;
    int   m_cnt;

    function automatic logic exp_mod(input logic rt, input logic out, input logic d);
        return rt ? out : d;
    endfunction

    always @(posedge clk) begin
        bit tk;
        if (rst) begin
            m_d1 <= 1; m_d <= 1; m_s1 <= 1; m_s <= 1; m_sd <= 1;
            m_hold <= 1; m_out <= 1; m_rt <= 0; m_req_n <= 1; m_cnt <= 0;
        end else begin
            tk = tick_en && (m_cnt == DIV - 1);
            m_d1 <= host_data;  m_d <= m_d1;
            m_s1 <= host_strobe; m_s <= m_s1; m_sd <= m_s;
            if (m_s && !m_sd) m_hold <= m_d;
            if (tick_en) m_cnt <= (m_cnt == DIV - 1) ? 0 : m_cnt + 1;
            if (tk) begin
                m_out   <= m_hold;
                m_rt    <= !m_s;
                m_req_n <= m_s;
            end else if (m_rt && !m_req_n && m_s) begin
                m_req_n <= 1;
            end
        end
    end

    always @(negedge clk) begin
        if (cmp_on && !rst) begin
            check(mod_data, exp_mod(m_rt, m_out, m_d), m_rt ? "R5 model" : "R2 model");
            check(load_req_n, m_req_n, "R6/R7 model");
        end
    end

    task automatic wait_req(input logic lvl, output bit ok);
        ok = 0;
        for (int i = 0; i < 4*DIV; i++) begin
            @(negedge clk);
            if (load_req_n == lvl) begin ok = 1; break; end
        end
    endtask

    task automatic send_bit(input logic b, input logic prev);
        bit ok;
        wait_req(1'b0, ok);
        check(ok, 1'b1, "R6 request seen");
        check(mod_data, prev, "R5 previous bit held");
        host_data = b;
        host_strobe = 1'b1;
        repeat (3) @(negedge clk);
        check(load_req_n, 1'b1, "R7 release");
        check(mod_data, prev, "R5 unchanged before tick");
        host_strobe = 1'b0;
        wait_req(1'b0, ok);
        check(mod_data, b, "R8 bit at tick");
        // hand back in the state send_bit expects: request active
        host_data = $urandom_range(0, 1);
    endtask

    initial begin
        void'($urandom(32'h5EED_1234));
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic prev;
        bit ok;
        repeat (4) @(negedge clk);
        check(mod_data, 1'b1, "R1 mod_data in reset");
        check(load_req_n, 1'b1, "R1 load_req_n in reset");
        rst = 1'b0;
        @(negedge clk);
        check(mod_data, 1'b1, "R1 mark after reset");
        check(load_req_n, 1'b1, "R1 idle after reset");
        cmp_on = 1'b1;

        // R2: transparent path, two-edge delay
        host_data = 1'b0;
        @(negedge clk);
        check(mod_data, 1'b1, "R2 not yet after one edge");
        @(negedge clk);
        check(mod_data, 1'b0, "R2 follows after two edges");
        for (int i = 0; i < 40; i++) begin
            host_data = $urandom_range(0, 1);
            @(negedge clk);
        end

        // R3: no tick while disabled, so no mode change
        tick_en = 1'b0;
        host_strobe = 1'b0;
        repeat (3 * DIV) @(negedge clk);
        check(load_req_n, 1'b1, "R3 no request without ticks");
        host_data = 1'b1;
        repeat (2) @(negedge clk);
        check(mod_data, 1'b1, "R3 still transparent");
        host_data = 1'b0;
        repeat (2) @(negedge clk);
        check(mod_data, 1'b0, "R3 still transparent low");
        host_data = 1'b1;
        tick_en = 1'b1;
        wait_req(1'b0, ok);
        check(ok, 1'b1, "R4 retimed entered at tick");
        check(mod_data, 1'b1, "R4 output stage mark");

        // R8: handshake stream of random bits
        prev = 1'b1;
        for (int i = 0; i < 24; i++) begin
            logic b;
            b = $urandom_range(0, 1);
            send_bit(b, prev);
            prev = b;
        end

        // R4: leave retimed mode by holding strobe high
        host_data = prev;
        host_strobe = 1'b1;
        repeat (3) @(negedge clk);
        check(mod_data, prev, "R4 retimed until next tick");
        wait_req(1'b1, ok);
        repeat (2 * DIV) @(negedge clk);
        host_data = ~prev;
        repeat (2) @(negedge clk);
        check(mod_data, ~prev, "R4 transparent after tick");

        // random activity checked by the model
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(0, 3) == 0) host_data = ~host_data;
            if ($urandom_range(0, 7) == 0) host_strobe = ~host_strobe;
            if ($urandom_range(0, 31) == 0) tick_en = ~tick_en;
            else if (!tick_en && $urandom_range(0, 3) == 0) tick_en = 1'b1;
            @(negedge clk);
        end

        cmp_on = 1'b0;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule